// File: doc/BRIEF.md
# Reloading Interval Timer with Interrupt

This block produces a periodic system tick. A down-counter is decremented once per enabled base-rate strobe (`tick_i`). When it runs out, it refills itself from a divider register and raises a pending interrupt. With a 100 MHz strobe and a divider of 1,000,000, the period is 10 ms (100 Hz). Each period lasts exactly `divider` strobes.

Software controls the timer through a flat register port. The port has one write strobe, one address and a combinational read path. The divider is written first. A control write then issues one operation:
- load copies the divider into the counter and leaves the counter idle;
- run starts counting;
- stop freezes the counter.

The live count can be read at any time. The strobes elapsed since the last tick equal the divider minus the value read. The divider may be rewritten while the timer runs; the new value is used at the next refill. The interrupt side has a mask register, a raw status bit and a masked status bit. A write-one-to-clear acknowledge register clears the pending bit.

Top module: `tick_timer`

Register offsets (addr_i): 0 divider (rw), 1 control (write: op in wdata[1:0]; read: bit0 = running), 2 count (ro), 3 mask (rw, bit0), 4 raw status (ro, bit0), 5 masked status (ro, bit0), 6 acknowledge (wo, reads 0), 7 reads 0.

## Requirements
- R1: After `rst_ni` is asserted, divider, count, mask and raw status read 0, the control register reads 0 (stopped), and `irq_o` is 0.
- R2: A control write with op 1 (load) sets the count to the divider value in the next cycle and stops the timer, so later strobes leave the count unchanged.
- R3: While running, each cycle with `tick_i` high and count above 1 lowers the count by exactly one; cycles without `tick_i` leave the count unchanged.
- R4: While running, a strobe with count at 1 or 0 refills the count from the divider and sets raw status bit0 in the next cycle, giving a period of `divider` strobes.
- R5: Op 0 (stop) holds the count at its present value, and a control write in the same cycle as a strobe takes precedence over the strobe. Op 3 has no effect, so a strobe in that cycle still counts.
- R6: Writing the divider while running does not change the current count; the new value is loaded at the next refill.
- R7: Masked status bit0 and `irq_o` both equal raw status AND mask bit0.
- R8: Writing the acknowledge register with wdata[0]=1 clears raw status; writing it with wdata[0]=0 leaves raw status unchanged.
- R9: If a refill and an acknowledge occur in the same cycle, raw status is set afterwards.
- R10: Op 2 (run) makes the control register read 1 and starts counting on the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base-rate count enable strobe |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Combinational read data for addr_i |
| irq_o | output | 1 | Masked timer interrupt |

## Verification
A vector table drives mixed patterns through the timer:
- a full count-down to refill with a small divider, which separates an off-by-one period from a correct one;
- cycles with and without the strobe, which show whether counting is gated by the enable;
- a divider rewrite mid-period, which tells a count that is disturbed immediately from one that picks up the new value only at the refill.

Further vectors cover the interrupt side and the control operations:
- an acknowledge landing on a refill, a zero-valued acknowledge, and mask toggling, which separate correct priority, the write-one rule and correct masking from faulty versions;
- stop and the unused op, each coinciding with a strobe, which show whether control writes win over counting.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DIV    = 3'd0,
    A_CTRL   = 3'd1,
    A_COUNT  = 3'd2,
    A_MASK   = 3'd3,
    A_RAW    = 3'd4,
    A_MASKED = 3'd5,
    A_ACK    = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    OP_STOP = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2,
    OP_NONE = 2'd3
  } op_e;
endpackage

// File: rtl/tt_count.sv
module tt_count
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] div_i,
  input  logic             op_valid_i,
  input  op_e              op_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             run_q;
  logic             ctrl_hit;

  // reserved op does not block counting
  assign ctrl_hit = op_valid_i && (op_i != OP_NONE);
  assign wrap_o   = run_q && tick_i && !ctrl_hit && (count_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (ctrl_hit) begin
      unique case (op_i)
        OP_LOAD: begin
          count_q <= div_i;
          run_q   <= 1'b0;
        end
        OP_RUN:  run_q <= 1'b1;
        default: run_q <= 1'b0;
      endcase
    end else if (run_q && tick_i) begin
      count_q <= wrap_o ? div_i : count_q - ONE;
    end
  end

  assign count_o = count_q;
  assign run_o   = run_q;
endmodule

// File: rtl/tt_irq.sv
module tt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic ack_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic raw_o,
  output logic mask_o,
  output logic masked_o
);
  logic raw_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (wrap_i)     raw_q <= 1'b1;  // new event beats ack
      else if (ack_i) raw_q <= 1'b0;
      if (mask_we_i)  mask_q <= mask_d_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] count_q;
  logic             run_q, raw_q, mask_q, masked;
  logic             wrap;
  logic             wr_ctrl, wr_mask, wr_ack;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_mask = we_i && (addr_i == A_MASK);
  assign wr_ack  = we_i && (addr_i == A_ACK) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        div_q <= '0;
    else if (we_i && addr_i == A_DIV)   div_q <= wdata_i;
  end

  tt_count #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .div_i      (div_q),
    .op_valid_i (wr_ctrl),
    .op_i       (op_e'(wdata_i[1:0])),
    .count_o    (count_q),
    .run_o      (run_q),
    .wrap_o     (wrap)
  );

  tt_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (wrap),
    .ack_i     (wr_ack),
    .mask_we_i (wr_mask),
    .mask_d_i  (wdata_i[0]),
    .raw_o     (raw_q),
    .mask_o    (mask_q),
    .masked_o  (masked)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DIV:    rdata_o = div_q;
      A_CTRL:   rdata_o[0] = run_q;
      A_COUNT:  rdata_o = count_q;
      A_MASK:   rdata_o[0] = mask_q;
      A_RAW:    rdata_o[0] = raw_q;
      A_MASKED: rdata_o[0] = masked;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = masked;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  div_q,
  input logic              run_q,
  input logic              raw_q,
  input logic              mask_q
);
  logic ctrl_w, ack_w, under;
  assign ctrl_w = we_i && addr_i == A_CTRL && wdata_i[1:0] != OP_NONE;
  assign ack_w  = we_i && addr_i == A_ACK && wdata_i[0];
  assign under  = run_q && tick_i && !ctrl_w && count_q <= CNT_W'(1);

  // R2
  load_copies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_w && wdata_i[1:0] == OP_LOAD |=> count_q == $past(div_q) && !run_q);

  // R3
  dec_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && tick_i && !ctrl_w && count_q > CNT_W'(1) |=> count_q == $past(count_q) - CNT_W'(1));

  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    under |=> count_q == $past(div_q) && raw_q);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !ctrl_w |=> $stable(count_q));

  // R9
  wrap_beats_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    under && ack_w |=> raw_q);

  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (raw_q && mask_q));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .count_q (count_q),
  .div_q   (div_q),
  .run_q   (run_q),
  .raw_q   (raw_q),
  .mask_q  (mask_q)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int W = 32;

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [W-1:0] wd;
    logic        tk;
    logic [2:0]  rd;
    logic [W-1:0] exp;
    logic [3:0]  req;
  } vec_t;

  // addr: 0 div,1 ctrl,2 count,3 mask,4 raw,5 masked,6 ack ; ops 0 stop,1 load,2 run,3 none
  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 32'd5, 1'b0, 3'd0, 32'd5, 4'd6},   // div=5
    '{1'b1, 3'd1, 32'd1, 1'b0, 3'd2, 32'd5, 4'd2},   // R2 load
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd5, 4'd2},   // R2 no count after load
    '{1'b1, 3'd1, 32'd2, 1'b0, 3'd1, 32'd1, 4'd10},  // R10 run
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd4, 4'd3},   // R3
    '{1'b0, 3'd0, 32'd0, 1'b0, 3'd2, 32'd4, 4'd3},   // R3 no strobe
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd3, 4'd3},
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd2, 4'd3},
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd1, 4'd3},
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd4, 32'd1, 4'd4},   // R4 refill sets raw
    '{1'b0, 3'd0, 32'd0, 1'b0, 3'd2, 32'd5, 4'd4},   // R4 refilled to 5
    '{1'b0, 3'd0, 32'd0, 1'b0, 3'd5, 32'd0, 4'd7},   // R7 masked off
    '{1'b1, 3'd3, 32'd1, 1'b0, 3'd5, 32'd1, 4'd7},   // R7 mask on
    '{1'b1, 3'd6, 32'd0, 1'b0, 3'd4, 32'd1, 4'd8},   // R8 zero ack
    '{1'b1, 3'd6, 32'd1, 1'b0, 3'd4, 32'd0, 4'd8},   // R8 ack clears
    '{1'b1, 3'd0, 32'd3, 1'b1, 3'd2, 32'd4, 4'd6},   // R6 div write mid-run
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd3, 4'd6},
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd2, 4'd6},
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd1, 4'd6},
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd3, 4'd6},   // R6 new div at refill
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd4, 32'd1, 4'd4},
    '{1'b1, 3'd6, 32'd1, 1'b1, 3'd4, 32'd0, 4'd8},   // ack, count 2->1
    '{1'b1, 3'd6, 32'd1, 1'b1, 3'd4, 32'd1, 4'd9},   // R9 refill + ack
    '{1'b1, 3'd1, 32'd0, 1'b1, 3'd2, 32'd3, 4'd5},   // R5 stop beats strobe
    '{1'b0, 3'd0, 32'd0, 1'b1, 3'd2, 32'd3, 4'd5},   // R5 held
    '{1'b1, 3'd1, 32'd2, 1'b0, 3'd1, 32'd1, 4'd10},  // R10
    '{1'b1, 3'd1, 32'd3, 1'b1, 3'd2, 32'd2, 4'd5}    // R5 op 3 no effect
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [W-1:0] wdata_i = '0, rdata_o;
  logic irq_o;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #10 clk_i = ~clk_i;

  tick_timer #(.CNT_W(W)) uut (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string req);
    addr_i = a;
    #1 check(req, rdata_o, exp);
  endtask

  initial begin
    #2;
    // R1 reset state
    rd(3'd0, 0, "R1"); rd(3'd1, 0, "R1"); rd(3'd2, 0, "R1");
    rd(3'd3, 0, "R1"); rd(3'd4, 0, "R1");
    check("R1", {31'd0, irq_o}, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      we_i = VECS[i].we; addr_i = VECS[i].addr; wdata_i = VECS[i].wd; tick_i = VECS[i].tk;
      @(posedge clk_i);
      #1 we_i = 1'b0; tick_i = 1'b0;
      rd(VECS[i].rd, VECS[i].exp, $sformatf("R%0d", VECS[i].req));
    end
    // R7 pending with mask on drives irq_o
    check("R7", {31'd0, irq_o}, 1);
    // R1 reset while running
    @(negedge clk_i) rst_ni = 1'b0;
    #2;
    rd(3'd0, 0, "R1"); rd(3'd1, 0, "R1"); rd(3'd2, 0, "R1");
    rd(3'd3, 0, "R1"); rd(3'd5, 0, "R1");
    check("R1", {31'd0, irq_o}, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule